// File: doc/BRIEF.md
# Configurable Asynchronous Character Receiver

This block recovers characters from an asynchronous serial input line. The line stays high when idle. Each character opens with a low start bit. Five to eight data bits follow, least significant first. An optional parity bit comes next, then a high stop bit. The character format comes from a few static configuration inputs: a two-bit length code, a parity enable, an even/odd select and a fixed-level parity option. A matching transmitter uses the same fields.

Timing comes from an oversampling strobe, `tick16`, that pulses once per sixteenth of a bit period. The input line passes through a synchroniser first. A falling edge is then confirmed half a bit later. After that, every bit is sampled once at its centre. When the stop bit has been sampled, the block presents the assembled byte for one clock, together with its parity, framing and break flags. The flags keep their values until the next character is delivered. The format inputs are captured when a start edge is seen, so changing them during a character has no effect on that character.

Top module: `serial_frame_rx`

## Requirements
- R1: The length code `len_sel` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits are assembled least significant first into `rx_data`, and bits above the configured length read as 0.
- R2: With `par_en`=1, exactly one parity bit is taken between the last data bit and the stop bit. With `par_en`=0, no parity bit is taken and `par_err` is 0.
- R3: When parity is enabled and `stick_par`=0, the data bits and the parity bit together must contain an even number of ones if `even_sel`=1, or an odd number if `even_sel`=0. Otherwise `par_err` is 1.
- R4: When parity is enabled and `stick_par`=1, the parity bit must equal the inverse of `even_sel`. Otherwise `par_err` is 1.
- R5: Only one stop bit is examined. A start bit that follows immediately after the first stop bit is received correctly.
- R6: A low pulse on `rxd` that is high again at the centre of the start bit (8 ticks after the edge is seen) produces no character.
- R7: `frm_err` is 1 when the stop bit is sampled low.
- R8: `brk_det` is 1, with `frm_err`=1 and `rx_data`=0, when all data bits, the parity bit (if enabled) and the stop bit are 0. After a break, no further character is started until `rxd` has returned high.
- R9: After reset, `rx_valid`, `rx_data`, `par_err`, `frm_err` and `brk_det` are all 0.
- R10: `rx_valid` is a single-clock pulse, and it occurs on the clock after a `tick16` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit period |
| rxd | input | 1 | Serial data line, idle high |
| len_sel | input | 2 | Data length code (00=5 .. 11=8 bits) |
| par_en | input | 1 | Parity bit present |
| even_sel | input | 1 | 1 = even ones, 0 = odd ones |
| stick_par | input | 1 | Parity bit checked as a fixed level |
| rx_data | output | 8 | Received character, upper bits zero |
| rx_valid | output | 1 | One-clock strobe for a delivered character |
| par_err | output | 1 | Parity mismatch for the delivered character |
| frm_err | output | 1 | Stop bit sampled low |
| brk_det | output | 1 | Break condition detected |

## Verification
A break is the hardest case to reach from the ports, together with the re-arm condition that follows it. To produce one, the line must be held low through every data bit, the parity slot and the stop slot, and then kept low for several more bit times. In that extra low time the receiver must not start a phantom character. The stimulus does exactly this. It then releases the line and sends a normal character straight away to confirm that the receiver has re-armed. A nearly identical frame is also sent in which only the parity bit is high. That frame must show a framing error with no break. Start glitches and a start bit placed directly after a single stop bit are sent as well, so that false starts and missed starts both show up as unexpected or missing strobes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAIT
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       even;
    logic       stick;
  } rx_cfg_t;

  // number of data bits for a length code: 5..8
  function automatic logic [3:0] data_bits(logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // 1 when the parity bit disagrees with the selected rule
  function automatic logic parity_fault(logic [7:0] d, logic pbit,
                                        logic even, logic stick);
    logic odd_total;
    odd_total = (^d) ^ pbit;
    if (stick) return pbit != ~even;
    return even ? odd_total : ~odd_total;
  endfunction

  // line held at zero for the whole character
  function automatic logic is_break(logic [7:0] d, logic pen,
                                    logic pbit, logic stop_bit);
    return (d == 8'd0) && (!pen || !pbit) && !stop_bit;
  endfunction

endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int  STAGES    = 2,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{IDLE_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxf_bit_timer.sv
module rxf_bit_timer #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  output logic half_hit,
  output logic full_hit
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] HALF_M1 = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OSR - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= (cnt == FULL_M1) ? '0 : cnt + 1'b1;
  end

  assign half_hit = tick && (cnt == HALF_M1);
  assign full_hit = tick && (cnt == FULL_M1);
endmodule

// File: rtl/rxf_frame_fsm.sv
module rxf_frame_fsm
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd_s,
  input  rx_cfg_t    cfg_in,
  input  logic       half_hit,
  input  logic       full_hit,
  output logic       tmr_clear,
  output logic       start_glitch,
  output rx_cfg_t    cfg_q,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       par_err,
  output logic       frm_err,
  output logic       brk_det
);
  rx_state_e  state;
  logic [2:0] bit_idx;
  logic [7:0] data_q;
  logic       pbit;
  logic [3:0] last_idx;
  logic       stop_brk;

  assign last_idx  = data_bits(cfg_q.len) - 4'd1;
  assign stop_brk  = is_break(data_q, cfg_q.par_en, pbit, rxd_s);
  assign tmr_clear = (state == S_IDLE  && tick && !rxd_s) ||
                     (state == S_START && half_hit && !rxd_s);
  assign start_glitch = (state == S_START) && half_hit && rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bit_idx  <= '0;
      data_q   <= '0;
      pbit     <= 1'b0;
      cfg_q    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      brk_det  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        S_IDLE: if (tick && !rxd_s) begin
          state <= S_START;
          cfg_q <= cfg_in;
        end
        S_START: if (half_hit) begin
          if (rxd_s) state <= S_IDLE;
          else begin
            state   <= S_DATA;
            bit_idx <= '0;
            data_q  <= '0;
            pbit    <= 1'b0;
          end
        end
        S_DATA: if (full_hit) begin
          data_q[bit_idx] <= rxd_s;
          if ({1'b0, bit_idx} == last_idx)
            state <= cfg_q.par_en ? S_PAR : S_STOP;
          else
            bit_idx <= bit_idx + 3'd1;
        end
        S_PAR: if (full_hit) begin
          pbit  <= rxd_s;
          state <= S_STOP;
        end
        S_STOP: if (full_hit) begin
          rx_valid <= 1'b1;
          rx_data  <= data_q;
          par_err  <= cfg_q.par_en &&
                      parity_fault(data_q, pbit, cfg_q.even, cfg_q.stick);
          frm_err  <= !rxd_s;
          brk_det  <= stop_brk;
          state    <= stop_brk ? S_WAIT : S_IDLE;
        end
        S_WAIT: if (tick && rxd_s) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import rxf_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       even_sel,
  input  logic       stick_par,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       par_err,
  output logic       frm_err,
  output logic       brk_det
);
  logic    rxd_s;
  logic    tmr_clear, half_hit, full_hit;
  logic    start_glitch;
  rx_cfg_t cfg_in, cfg_q;
  logic [1:0] frame_len;
  logic       frame_par_en;

  assign cfg_in = '{len: len_sel, par_en: par_en, even: even_sel,
                    stick: stick_par};
  assign frame_len    = cfg_q.len;
  assign frame_par_en = cfg_q.par_en;

  rxf_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  rxf_bit_timer #(.OSR(OSR)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .clear(tmr_clear),
    .half_hit(half_hit), .full_hit(full_hit)
  );

  rxf_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd_s(rxd_s),
    .cfg_in(cfg_in), .half_hit(half_hit), .full_hit(full_hit),
    .tmr_clear(tmr_clear), .start_glitch(start_glitch), .cfg_q(cfg_q),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err),
    .frm_err(frm_err), .brk_det(brk_det)
  );
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       par_err,
  input logic       frm_err,
  input logic       brk_det,
  input logic [1:0] frame_len,
  input logic       frame_par_en,
  input logic       start_glitch
);
  // R10: strobe lasts one clock
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10: strobe follows an oversampling tick
  a_r10_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(tick16));

  // R8: break implies framing error and zero data
  a_r8_break_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && brk_det) |-> (frm_err && rx_data == 8'd0));

  // R1: five-bit characters leave the top bits clear
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && frame_len == 2'b00) |-> (rx_data[7:5] == 3'b000));

  // R2: parity error only for characters that carried parity
  a_r2_par_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && par_err) |-> frame_par_en);

  // R6: a rejected start edge delivers nothing next clock
  a_r6_glitch_silent: assert property (@(posedge clk) disable iff (!rst_n)
    start_glitch |=> !rx_valid);
endmodule

bind serial_frame_rx rxf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_data(rx_data),
  .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err),
  .brk_det(brk_det), .frame_len(frame_len), .frame_par_en(frame_par_en),
  .start_glitch(start_glitch)
);

// File: tb/tb_serial_frame_rx.sv
module tb_serial_frame_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] len_sel = 2'b11;
  logic       par_en = 1'b0, even_sel = 1'b0, stick_par = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, par_err, frm_err, brk_det;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  bit prev_valid = 1'b0;
  int tdiv = 0;

  typedef struct {
    logic [7:0] d;
    logic pe, fe, bk;
    string tag;
  } exp_t;
  exp_t expq[$];

  always #2 clk = ~clk;

  serial_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .len_sel(len_sel), .par_en(par_en), .even_sel(even_sel),
    .stick_par(stick_par), .rx_data(rx_data), .rx_valid(rx_valid),
    .par_err(par_err), .frm_err(frm_err), .brk_det(brk_det)
  );

  // oversampling strobe: one clock in four
  always @(negedge clk) begin
    if (!rst_n) begin tdiv = 0; tick16 = 1'b0; end
    else begin tdiv = (tdiv + 1) % 4; tick16 = (tdiv == 0); end
  end

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (rx_valid && prev_valid) begin
        miscompares++;
        $display("FAIL R10 strobe longer than one clock: actual 1 expected 0");
      end
      if (rx_valid) begin
        if (expq.size() == 0) begin
          miscompares++;
          $display("FAIL R6/R8 unexpected strobe: actual data %h expected none", rx_data);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (rx_data !== e.d || par_err !== e.pe || frm_err !== e.fe ||
              brk_det !== e.bk) begin
            miscompares++;
            $display("FAIL %s actual d=%h pe=%b fe=%b bk=%b expected d=%h pe=%b fe=%b bk=%b",
                     e.tag, rx_data, par_err, frm_err, brk_det, e.d, e.pe, e.fe, e.bk);
          end
        end
      end
      prev_valid = rx_valid;
    end
  end

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick16) @(posedge clk);
    end
  endtask

  task automatic drive_bit(logic v);
    @(negedge clk);
    rxd = v;
    ticks(16);
  endtask

  // build and send one character; flip inverts the correct parity bit
  task automatic send(logic [7:0] val, logic flip, logic stop_v,
                      int idle_bits, string tag);
    int n, ones;
    logic [7:0] m;
    logic pb, pe;
    exp_t e;
    n = 5 + int'(len_sel);
    m = 8'd0;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      m[i] = val[i];
      if (val[i]) ones++;
    end
    if (stick_par) pb = ~even_sel;
    else           pb = even_sel ? logic'(ones % 2) : logic'((ones + 1) % 2);
    pb = pb ^ flip;
    if (!par_en)        pe = 1'b0;
    else if (stick_par) pe = (pb != !even_sel);
    else if (even_sel)  pe = ((ones + int'(pb)) % 2) != 0;
    else                pe = ((ones + int'(pb)) % 2) == 0;
    e.bk = (m == 8'd0) && (!par_en || !pb) && !stop_v;
    e.d  = m;
    e.pe = pe;
    e.fe = !stop_v;
    e.tag = tag;
    expq.push_back(e);
    drive_bit(1'b0);
    for (int i = 0; i < n; i++) drive_bit(m[i]);
    if (par_en) drive_bit(pb);
    drive_bit(stop_v);
    for (int i = 0; i < idle_bits; i++) drive_bit(1'b1);
  endtask

  task automatic cfg(logic [1:0] l, logic pen, logic ev, logic st);
    @(negedge clk);
    len_sel = l; par_en = pen; even_sel = ev; stick_par = st;
  endtask

  task automatic chk_empty(string tag);
    vectors++;
    if (expq.size() != 0) begin
      miscompares++;
      $display("FAIL %s missing strobe: actual %0d pending expected 0", tag, expq.size());
      expq.delete();
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    if (rx_valid !== 1'b0 || rx_data !== 8'd0 || par_err !== 1'b0 ||
        frm_err !== 1'b0 || brk_det !== 1'b0) begin
      miscompares++;
      $display("FAIL R9 reset state: actual v=%b d=%h pe=%b fe=%b bk=%b expected all 0",
               rx_valid, rx_data, par_err, frm_err, brk_det);
    end
    drive_bit(1'b1);

    // R1: all lengths, LSB first, upper bits cleared
    cfg(2'b11, 0, 0, 0); send(8'hA5, 0, 1, 1, "R1 len8 A5"); send(8'h3C, 0, 1, 1, "R1 len8 3C");
    cfg(2'b00, 0, 0, 0); send(8'hFF, 0, 1, 1, "R1 len5 FF");
    cfg(2'b01, 0, 0, 0); send(8'hD2, 0, 1, 1, "R1 len6 D2");
    cfg(2'b10, 0, 0, 0); send(8'h81, 0, 1, 1, "R1 len7 81");

    // R2/R3: odd and even parity, good and bad
    cfg(2'b11, 1, 0, 0); send(8'h01, 0, 1, 1, "R3 odd ok"); send(8'h01, 1, 1, 1, "R3 odd bad");
    cfg(2'b11, 1, 1, 0); send(8'h77, 0, 1, 1, "R3 even ok"); send(8'h77, 1, 1, 1, "R3 even bad");
    cfg(2'b00, 1, 1, 0); send(8'h15, 0, 1, 1, "R2 len5 parity slot"); send(8'h15, 1, 1, 1, "R2 len5 parity bad");

    // R4: fixed-level parity
    cfg(2'b11, 1, 0, 1); send(8'h5A, 0, 1, 1, "R4 stick high ok"); send(8'h5A, 1, 1, 1, "R4 stick high bad");
    cfg(2'b10, 1, 1, 1); send(8'h0F, 0, 1, 1, "R4 stick low ok"); send(8'h0F, 1, 1, 1, "R4 stick low bad");

    // R5: start bit right after a single stop bit
    cfg(2'b11, 0, 0, 0);
    send(8'hC3, 0, 1, 0, "R5 back-to-back 1"); send(8'h3E, 0, 1, 0, "R5 back-to-back 2");
    send(8'h99, 0, 1, 1, "R5 back-to-back 3");

    // R6: short low pulse
    @(negedge clk) rxd = 1'b0; ticks(4);
    @(negedge clk) rxd = 1'b1; ticks(32);
    chk_empty("R6 glitch");
    send(8'h42, 0, 1, 1, "R6 after glitch");

    // R7: stop bit low, data not zero
    send(8'h55, 0, 0, 2, "R7 framing");
    chk_empty("R7 framing");

    // R8: parity bit high keeps it from being a break
    cfg(2'b11, 1, 0, 0);
    send(8'h00, 0, 0, 2, "R8 zero data parity high");
    chk_empty("R8 near break");

    // R8: full break, held low, then re-arm
    cfg(2'b11, 1, 1, 0);
    send(8'h00, 0, 0, 0, "R8 break");
    for (int i = 0; i < 3; i++) drive_bit(1'b0);
    chk_empty("R8 break hold");
    drive_bit(1'b1);
    send(8'h81, 0, 1, 1, "R8 rearm");
    chk_empty("R8 rearm");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule